// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Controller

This controller moves a contiguous run of 32-bit words between main memory and a slow, byte-wide peripheral. For each word it borrows one memory cycle from the processor. Software sets up four things while the controller is idle: which peripheral to select, the first memory word address, the number of words, and the transfer direction. Setting the go bit starts the transfer. The peripheral then offers bytes (device to memory) or asks for bytes (memory to device), one request/grant handshake per byte.

A 32-bit shift buffer with a 2-bit byte counter converts between bytes and words. When the buffer holds a full word, or needs a new one, the controller raises a memory-cycle request and holds it until the processor grants a cycle. During that single granted cycle it drives the memory strobe, the address and the direction. After each word the address moves up by one and the remaining count goes down by one. When the count runs out, the controller raises a sticky interrupt, which software clears by writing a bit.

Top module: `cs_dma`

## Requirements
- R1: While reset is applied, and until the first transfer starts, `cyc_req`, `dev_gnt`, `mem_en`, `irq` and `busy` are all low.
- R2: Configuration writes (`cfg_we` high) use these offsets on `cfg_addr`:
  - 0 selects the peripheral, which is driven on `dev_sel`.
  - 1 sets the start word address.
  - 2 sets the word count.
  - 3 is control: bit 0 = go, bit 1 = direction (1 = memory to device, 0 = device to memory), bit 2 = clear interrupt.
- R3: Device to memory: a byte on `dev_din` is taken at the clock edge that ends a cycle in which `dev_gnt` is high. Each byte shifts the buffer left by 8 bits, so the first of four bytes ends up in bits 31:24 of the stored word and the fourth in bits 7:0.
- R4: `cyc_req` stays high until `cyc_gnt` is seen. `mem_en` is high for exactly one cycle per word: the cycle in which both `cyc_req` and `cyc_gnt` are high. In that cycle `mem_we` is 1 for device to memory and 0 for memory to device.
- R5: Memory to device: the first word is read from memory before `dev_gnt` is first raised. The bytes of each word appear on `dev_dout` starting with bits 7:0, shifting right by 8 bits per byte taken.
- R6: Word k of a block uses memory address start+k. Exactly `count` memory cycles take place, and the word after the block is not touched.
- R7: `irq` rises when the last word finishes and stays high until a control write with bit 2 set.
- R8: While `busy` is high, writes to offsets 0, 1 and 2, and go commands, have no effect on the transfer in progress.
- R9: A go command with a word count of 0 raises `irq` without any memory cycle or device grant.
- R10: `dev_gnt` is high only while `dev_req` is high and no memory-cycle request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| irq | output | 1 | Sticky completion interrupt |
| busy | output | 1 | Transfer in progress |
| cyc_req | output | 1 | Memory-cycle request to the processor |
| cyc_gnt | input | 1 | Memory-cycle grant from the processor |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Word written to memory |
| mem_rdata | input | 32 | Word read from memory, valid in the strobe cycle |
| dev_sel | output | 8 | Selected peripheral number |
| dev_req | input | 1 | Byte request from the peripheral |
| dev_gnt | output | 1 | Byte grant to the peripheral |
| dev_din | input | 8 | Byte from the peripheral |
| dev_dout | output | 8 | Byte to the peripheral |

## Verification
Some results appear in the same cycle as their cause:
- `dev_gnt` follows `dev_req` combinationally while a byte is due, and the byte moves at the next edge.
- `mem_en`, `mem_we` and `mem_addr` are valid in the cycle the grant is seen.

Other results take one edge:
- The address step, the count step and `irq` appear after the edge that ends the grant cycle.
- A configuration write takes effect at the edge that ends its write cycle.

The bench drives inputs and samples outputs at the falling edge, 1 ns after it. It polls for `irq` with a bounded wait, and it checks a held request at fixed falling edges well inside a six-cycle grant delay.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2,
    ST_STORE = 2'd3
  } xfer_state_t;

  localparam logic [1:0] OFS_DEV   = 2'd0;
  localparam logic [1:0] OFS_ADDR  = 2'd1;
  localparam logic [1:0] OFS_COUNT = 2'd2;
  localparam logic [1:0] OFS_CTRL  = 2'd3;

  localparam int CTRL_GO  = 0;
  localparam int CTRL_DIR = 1;
  localparam int CTRL_CLR = 2;
endpackage

// File: rtl/cs_dma_regs.sv
module cs_dma_regs
  import cs_dma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CNTW = 16,
  parameter int DEVW = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            busy,
  input  logic            adv,
  input  logic            done,
  output logic [AW-1:0]   mem_addr,
  output logic [CNTW-1:0] wcnt,
  output logic [DEVW-1:0] dev_sel,
  output logic            dir_out,
  output logic            irq
);
  logic            wr_ok;
  logic            addr_en, cnt_en, dev_en, dir_en, irq_en;
  logic [AW-1:0]   addr_q, addr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [DEVW-1:0] dev_q;
  logic            dir_q, irq_q, irq_d;

  always_comb begin
    wr_ok   = cfg_we && !busy;
    dev_en  = wr_ok && (cfg_addr == OFS_DEV);
    dir_en  = wr_ok && (cfg_addr == OFS_CTRL);
    addr_en = adv || (wr_ok && (cfg_addr == OFS_ADDR));
    cnt_en  = adv || (wr_ok && (cfg_addr == OFS_COUNT));
    addr_d  = adv ? addr_q + 1'b1 : cfg_wdata[AW-1:0];
    cnt_d   = adv ? cnt_q - 1'b1 : cfg_wdata[CNTW-1:0];
    irq_en  = done || (cfg_we && (cfg_addr == OFS_CTRL) && cfg_wdata[CTRL_CLR]);
    irq_d   = done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      dev_q  <= '0;
      dir_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (dev_en)  dev_q  <= cfg_wdata[DEVW-1:0];
      if (dir_en)  dir_q  <= cfg_wdata[CTRL_DIR];
      if (irq_en)  irq_q  <= irq_d;
    end
  end

  assign mem_addr = addr_q;
  assign wcnt     = cnt_q;
  assign dev_sel  = dev_q;
  assign dir_out  = dir_q;
  assign irq      = irq_q;
endmodule

// File: rtl/cs_dma_pack.sv
module cs_dma_pack #(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          shift_in,
  input  logic          shift_out,
  input  logic          clr,
  input  logic [BW-1:0] din,
  output logic [DW-1:0] word,
  output logic [BW-1:0] dout,
  output logic          full
);
  localparam int NB = DW / BW;
  localparam int CW = (NB > 1) ? $clog2(NB) : 1;

  logic [DW-1:0] buf_q, buf_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          buf_en, cnt_en;

  always_comb begin
    buf_en = load || shift_in || shift_out;
    cnt_en = clr || shift_in || shift_out;
    if (load)          buf_d = load_data;
    else if (shift_in) buf_d = {buf_q[DW-BW-1:0], din};
    else               buf_d = {{BW{1'b0}}, buf_q[DW-1:BW]};
    cnt_d = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else begin
      if (buf_en) buf_q <= buf_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign word = buf_q;
  assign dout = buf_q[BW-1:0];
  assign full = (cnt_q == CW'(NB - 1));
endmodule

// File: rtl/cs_dma_seq.sv
module cs_dma_seq
  import cs_dma_pkg::*;
#(
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            go_dir,
  input  logic            dir,
  input  logic [CNTW-1:0] wcnt,
  input  logic            dev_req,
  input  logic            cyc_gnt,
  input  logic            full,
  output logic            cyc_req,
  output logic            dev_gnt,
  output logic            mem_en,
  output logic            mem_we,
  output logic            adv,
  output logic            load,
  output logic            shift_in,
  output logic            shift_out,
  output logic            done,
  output logic            busy
);
  xfer_state_t st_q, st_d;
  logic        cnt_zero, cnt_one;

  always_comb begin
    cnt_zero  = (wcnt == '0);
    cnt_one   = (wcnt == CNTW'(1));
    st_d      = st_q;
    cyc_req   = 1'b0;
    dev_gnt   = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    adv       = 1'b0;
    load      = 1'b0;
    shift_in  = 1'b0;
    shift_out = 1'b0;
    done      = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (go) begin
          if (cnt_zero) done = 1'b1;
          else          st_d = go_dir ? ST_FETCH : ST_XFER;
        end
      end
      ST_FETCH: begin
        cyc_req = 1'b1;
        if (cyc_gnt) begin
          mem_en = 1'b1;
          load   = 1'b1;
          adv    = 1'b1;
          st_d   = ST_XFER;
        end
      end
      ST_XFER: begin
        if (dev_req) begin
          dev_gnt   = 1'b1;
          shift_out = dir;
          shift_in  = !dir;
          if (full) begin
            if (!dir)         st_d = ST_STORE;
            else if (cnt_zero) begin
              done = 1'b1;
              st_d = ST_IDLE;
            end else          st_d = ST_FETCH;
          end
        end
      end
      default: begin
        cyc_req = 1'b1;
        if (cyc_gnt) begin
          mem_en = 1'b1;
          mem_we = 1'b1;
          adv    = 1'b1;
          if (cnt_one) begin
            done = 1'b1;
            st_d = ST_IDLE;
          end else begin
            st_d = ST_XFER;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/cs_dma.sv
module cs_dma
  import cs_dma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CNTW = 16,
  parameter int DEVW = 8,
  parameter int DW   = 32,
  parameter int BW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic            irq,
  output logic            busy,
  output logic            cyc_req,
  input  logic            cyc_gnt,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DEVW-1:0] dev_sel,
  input  logic            dev_req,
  output logic            dev_gnt,
  input  logic [BW-1:0]   dev_din,
  output logic [BW-1:0]   dev_dout
);
  logic [1:0]      rst_sync;
  logic            rst_int_n;
  logic            go, adv, done, load, shift_in, shift_out, full, dir;
  logic [CNTW-1:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign go = cfg_we && (cfg_addr == OFS_CTRL) && cfg_wdata[CTRL_GO];

  cs_dma_regs #(.AW(AW), .CNTW(CNTW), .DEVW(DEVW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .adv(adv), .done(done),
    .mem_addr(mem_addr), .wcnt(wcnt), .dev_sel(dev_sel), .dir_out(dir),
    .irq(irq)
  );

  cs_dma_pack #(.DW(DW), .BW(BW)) u_pack (
    .clk(clk), .rst_n(rst_int_n), .load(load), .load_data(mem_rdata),
    .shift_in(shift_in), .shift_out(shift_out), .clr(mem_en), .din(dev_din),
    .word(mem_wdata), .dout(dev_dout), .full(full)
  );

  cs_dma_seq #(.CNTW(CNTW)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .go(go), .go_dir(cfg_wdata[CTRL_DIR]),
    .dir(dir), .wcnt(wcnt), .dev_req(dev_req), .cyc_gnt(cyc_gnt),
    .full(full), .cyc_req(cyc_req), .dev_gnt(dev_gnt), .mem_en(mem_en),
    .mem_we(mem_we), .adv(adv), .load(load), .shift_in(shift_in),
    .shift_out(shift_out), .done(done), .busy(busy)
  );
endmodule

// File: rtl/cs_dma_chk.sv
module cs_dma_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_addr,
  input logic [DW-1:0] cfg_wdata,
  input logic          irq,
  input logic          busy,
  input logic          cyc_req,
  input logic          cyc_gnt,
  input logic          mem_en,
  input logic [AW-1:0] mem_addr,
  input logic          dev_req,
  input logic          dev_gnt
);
  logic clr_wr;
  assign clr_wr = cfg_we && (cfg_addr == 2'd3) && cfg_wdata[2];

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cyc_req && !dev_gnt && !mem_en)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && !cyc_gnt) |=> cyc_req); // R4
  AST_STROBE_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (cyc_req && cyc_gnt)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> (mem_addr == $past(mem_addr) + 1'b1)); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq); // R7
  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dev_gnt |-> (dev_req && !cyc_req)); // R10
endmodule

bind cs_dma cs_dma_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .irq(irq), .busy(busy), .cyc_req(cyc_req),
  .cyc_gnt(cyc_gnt), .mem_en(mem_en), .mem_addr(mem_addr),
  .dev_req(dev_req), .dev_gnt(dev_gnt)
);

// File: tb/cs_dma_bench.sv
`timescale 1ns/1ps
module cs_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        irq, busy, cyc_req, mem_en, mem_we, dev_gnt;
  logic        cyc_gnt = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0]  dev_sel, dev_dout;
  logic        dev_req = 1'b0;
  logic [7:0]  dev_din = 8'd0;

  logic [31:0] mem [0:255];
  logic        pl_we = 1'b0;
  logic [7:0]  pl_addr = 8'd0;
  logic [31:0] pl_data = 32'd0;
  int          gnt_delay = 0;
  int          gcnt = 0;
  int          acc_cnt = 0;
  int          rd_cnt = 0;
  int          cycles = 0;
  int          checks = 0;
  int          fails = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  cs_dma u_cs_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .irq(irq), .busy(busy), .cyc_req(cyc_req),
    .cyc_gnt(cyc_gnt), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_sel(dev_sel),
    .dev_req(dev_req), .dev_gnt(dev_gnt), .dev_din(dev_din), .dev_dout(dev_dout)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (pl_we) mem[pl_addr] <= pl_data;
    else if (mem_en && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_en) acc_cnt <= acc_cnt + 1;
    if (mem_en && !mem_we) rd_cnt <= rd_cnt + 1;
    if (!cyc_req || cyc_gnt) begin
      gcnt    <= 0;
      cyc_gnt <= 1'b0;
    end else if (gcnt >= gnt_delay) begin
      cyc_gnt <= 1'b1;
    end else begin
      gcnt <= gcnt + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // gnt delay (2b), dir (1b: 1 = memory to device), start addr, words, seed
  localparam logic [26:0] VEC [0:5] = '{
    {2'd0, 1'b0, 8'h10, 8'd1, 8'h03},
    {2'd1, 1'b0, 8'h20, 8'd3, 8'h09},
    {2'd2, 1'b1, 8'h30, 8'd1, 8'h05},
    {2'd0, 1'b1, 8'h38, 8'd4, 8'h0B},
    {2'd3, 1'b0, 8'h50, 8'd2, 8'h77},
    {2'd1, 1'b1, 8'hA0, 8'd2, 8'h5C}
  };

  function automatic logic [7:0] bval(input logic [7:0] s, input int w, input int k);
    return 8'(int'(s) * 31 + w * 17 + k * 5 + 1);
  endfunction

  function automatic logic [31:0] in_word(input logic [7:0] s, input int w);
    return {bval(s, w, 0), bval(s, w, 1), bval(s, w, 2), bval(s, w, 3)};
  endfunction

  function automatic logic [31:0] out_word(input logic [7:0] s, input int w);
    return {bval(s, w, 3), bval(s, w, 2), bval(s, w, 1), bval(s, w, 0)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic dev_put(input logic [7:0] b);
    @(negedge clk);
    dev_req = 1'b1; dev_din = b;
    for (int g = 0; g < 400; g++) begin
      #1;
      if (dev_gnt) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    dev_req = 1'b0;
  endtask

  task automatic dev_get(output logic [7:0] b, output bit early);
    early = 1'b0;
    b = 8'h00;
    @(negedge clk);
    dev_req = 1'b1;
    for (int g = 0; g < 400; g++) begin
      #1;
      if (dev_gnt) break;
      @(negedge clk);
    end
    b = dev_dout;
    if (rd_cnt == 0) early = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dev_req = 1'b0;
  endtask

  task automatic wait_irq();
    for (int g = 0; g < 60; g++) begin
      @(negedge clk);
      #1;
      if (irq) break;
    end
  endtask

  task automatic run_block(input logic [26:0] v);
    logic [7:0] a, n, s, b;
    bit         dir, early;
    int         base;
    a = v[23:16]; n = v[15:8]; s = v[7:0]; dir = v[24];
    gnt_delay = int'(v[26:25]);
    for (int w = 0; w <= int'(n); w++)
      poke(a + 8'(w), (dir && w < int'(n)) ? out_word(s, w) : 32'hDEAD_BEEF);
    cfg_wr(2'd0, {24'd0, s});
    cfg_wr(2'd1, {24'd0, a});
    cfg_wr(2'd2, {24'd0, n});
    base = acc_cnt;
    rd_cnt = 0;
    cfg_wr(2'd3, {30'd0, dir, 1'b1});
    for (int w = 0; w < int'(n); w++) begin
      for (int k = 0; k < 4; k++) begin
        if (dir) begin
          dev_get(b, early);
          chk(b == bval(s, w, k), "R5 byte order out", {24'd0, b}, {24'd0, bval(s, w, k)});
          if (w == 0 && k == 0)
            chk(!early, "R5 first word fetched before grant", {31'd0, early}, 32'd0);
        end else begin
          dev_put(bval(s, w, k));
        end
      end
    end
    wait_irq();
    chk(irq == 1'b1, "R7 irq on completion", {31'd0, irq}, 32'd1);
    chk(acc_cnt - base == int'(n), "R6 memory cycles per block", acc_cnt - base, {24'd0, n});
    chk(mem[a + n] == 32'hDEAD_BEEF, "R6 word after block untouched", mem[a + n], 32'hDEAD_BEEF);
    chk(dev_sel == s, "R2 device select", {24'd0, dev_sel}, {24'd0, s});
    if (!dir)
      for (int w = 0; w < int'(n); w++)
        chk(mem[a + 8'(w)] == in_word(s, w), "R3 packed word", mem[a + 8'(w)], in_word(s, w));
    repeat (3) @(negedge clk);
    #1;
    chk(irq == 1'b1, "R7 irq held", {31'd0, irq}, 32'd1);
    cfg_wr(2'd3, 32'h4);
    #1;
    chk(irq == 1'b0, "R7 irq cleared", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    int base;
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    #1;
    chk({cyc_req, dev_gnt, mem_en, irq, busy} == 5'd0, "R1 reset outputs",
        {27'd0, cyc_req, dev_gnt, mem_en, irq, busy}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk({cyc_req, dev_gnt, mem_en, irq, busy} == 5'd0, "R1 idle after reset",
        {27'd0, cyc_req, dev_gnt, mem_en, irq, busy}, 32'd0);

    foreach (VEC[i]) run_block(VEC[i]);

    // R9: zero word count
    gnt_delay = 0;
    cfg_wr(2'd2, 32'd0);
    base = acc_cnt;
    cfg_wr(2'd3, 32'h1);
    @(negedge clk);
    #1;
    chk(irq == 1'b1, "R9 zero count irq", {31'd0, irq}, 32'd1);
    chk(acc_cnt == base, "R9 zero count no memory cycle", acc_cnt - base, 32'd0);
    chk(busy == 1'b0, "R9 zero count stays idle", {31'd0, busy}, 32'd0);
    cfg_wr(2'd3, 32'h4);

    // R4 / R10: held request with slow grant, device request pending
    gnt_delay = 6;
    poke(8'h60, 32'hDEAD_BEEF);
    cfg_wr(2'd1, 32'h60);
    cfg_wr(2'd2, 32'd1);
    base = acc_cnt;
    cfg_wr(2'd3, 32'h1);
    for (int k = 0; k < 4; k++) dev_put(bval(8'h42, 0, k));
    dev_req = 1'b1;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(cyc_req == 1'b1, "R4 request held until grant", {31'd0, cyc_req}, 32'd1);
      chk(mem_en == 1'b0, "R4 no strobe before grant", {31'd0, mem_en}, 32'd0);
      chk(dev_gnt == 1'b0, "R10 no byte grant while cycle pending", {31'd0, dev_gnt}, 32'd0);
      @(negedge clk);
    end
    dev_req = 1'b0;
    wait_irq();
    chk(mem[8'h60] == in_word(8'h42, 0), "R4 word written after late grant", mem[8'h60], in_word(8'h42, 0));
    chk(acc_cnt - base == 1, "R4 one strobe per word", acc_cnt - base, 32'd1);
    cfg_wr(2'd3, 32'h4);

    // R8: writes while busy are ignored
    gnt_delay = 0;
    poke(8'h41, 32'hDEAD_BEEF);
    poke(8'h80, 32'hDEAD_BEEF);
    cfg_wr(2'd0, 32'h21);
    cfg_wr(2'd1, 32'h40);
    cfg_wr(2'd2, 32'd2);
    base = acc_cnt;
    cfg_wr(2'd3, 32'h1);
    for (int k = 0; k < 4; k++) dev_put(bval(8'h21, 0, k));
    cfg_wr(2'd0, 32'h99);
    cfg_wr(2'd1, 32'h80);
    cfg_wr(2'd2, 32'd9);
    cfg_wr(2'd3, 32'h3);
    #1;
    chk(dev_sel == 8'h21, "R8 device select kept while busy", {24'd0, dev_sel}, 32'h21);
    for (int k = 0; k < 4; k++) dev_put(bval(8'h21, 1, k));
    wait_irq();
    chk(irq == 1'b1, "R8 finishes original count", {31'd0, irq}, 32'd1);
    chk(mem[8'h41] == in_word(8'h21, 1), "R8 second word at original address", mem[8'h41], in_word(8'h21, 1));
    chk(mem[8'h80] == 32'hDEAD_BEEF, "R8 new address ignored", mem[8'h80], 32'hDEAD_BEEF);
    chk(acc_cnt - base == 2, "R8 new count ignored", acc_cnt - base, 32'd2);
    cfg_wr(2'd3, 32'h4);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule